// File: doc/BRIEF.md
# Pad Input Capture Path with Two-Clock Front Latch

This block models the receive side of a configurable pad cell for a bank of `WIDTH` pads. Every pad value reaches two internal taps. Each tap carries either the plain pad value or the output of a per-pad storage element. That element runs either as an edge-triggered flip-flop or as a latch that is transparent while its capture clock is high. In front of it there is an optional front latch, transparent while a second, unrelated launch clock is low. The value is first caught under the launch clock and then handed to the capture clock.

The block runs on one fast fabric clock `clk`. The pad bank and the two pad-side clocks `ik` (capture) and `ok` (launch) are sampled on every `clk` edge, and edges and levels of those clocks are judged from the samples. Configuration inputs are held static between resets. They select the storage mode, the polarity of each pad-side clock, whether the front latch is used, the value loaded by reset, and the source of each tap. A synchronous active-high `rst` is the global set/reset.

Top module: `iocap_input_path`

## Requirements
- R1: While `rst` is high, `tap_a` and `tap_b` read 0 from the second edge on, and every storage element is loaded with `cfg_set_val` (0 = reset, 1 = set). Until the first capture after release, a tap that selects the stored value shows `cfg_set_val` on every pad.
- R2: A tap whose select bit is 0 shows the pad value that was sampled two edges earlier, so it is visible after the third edge that counts from the sampling edge.
- R3: With `cfg_level_mode` = 0, the storage element loads its input only in a cycle where the effective capture clock is 1 and its previous sample was 0.
- R4: With `cfg_level_mode` = 1, the storage element loads its input in every sampled cycle where the effective capture clock is 1, so it follows the pad while that clock stays high.
- R5: With `ce` = 0 in a sampled cycle, the storage element keeps its value whatever the clocks and pads do.
- R6: With `cfg_front_en` = 1, the front latch passes the pad while the effective launch clock is 0 and holds the last passed value while it is 1. The storage element loads the front latch's view.
- R7: With `cfg_front_en` = 0, the storage element loads the pad value of the same sampled cycle, and the launch clock has no effect.
- R8: The effective capture clock is `ik` XOR `cfg_ik_inv` and the effective launch clock is `ok` XOR `cfg_ok_inv`.
- R9: `cfg_tap_a_reg` and `cfg_tap_b_reg` select the source of their own tap independently (1 = stored value, 0 = pad).
- R10: A stored-value result that is computed from inputs sampled at edge k appears on its tap after edge k+2, which is the same alignment as the direct path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high global set/reset |
| pad | input | WIDTH | Pad values of the bank |
| ik | input | 1 | Capture clock for the storage elements (sampled) |
| ok | input | 1 | Launch clock for the front latches (sampled) |
| ce | input | 1 | Active-high enable for the storage elements |
| cfg_level_mode | input | 1 | 0 = edge flip-flop, 1 = latch transparent while high |
| cfg_ik_inv | input | 1 | Invert the capture clock |
| cfg_ok_inv | input | 1 | Invert the launch clock |
| cfg_front_en | input | 1 | Put the front latch in the path |
| cfg_set_val | input | 1 | Value loaded by reset |
| cfg_tap_a_reg | input | 1 | Source of tap_a: 1 stored, 0 pad |
| cfg_tap_b_reg | input | 1 | Source of tap_b: 1 stored, 0 pad |
| tap_a | output | WIDTH | First internal tap |
| tap_b | output | WIDTH | Second internal tap |

## Verification
Inputs sampled at edge k pass through three register ranks: the sampling rank, the storage or delay rank, and the tap rank. Results from both the direct and the stored path are therefore due after edge k+2. The bench drives inputs at falling edges. It steps its reference model once per rising edge with the values it drove, keeps the two most recent predictions, and compares each tap one time unit after edge k+2 with the prediction made at edge k. The first two edges after reset release are skipped because the sampling rank still holds its reset contents. The bound properties use the same three-edge offset, and they are only armed once enough edges have passed since release.

// File: rtl/iocap_pkg.sv
package iocap_pkg;
  typedef enum logic {
    CAP_EDGE  = 1'b0,
    CAP_LEVEL = 1'b1
  } cap_mode_e;

  typedef enum logic {
    TAP_PAD = 1'b0,
    TAP_REG = 1'b1
  } tap_src_e;
endpackage

// File: rtl/iocap_sample_stage.sv
// Rank 1: samples pad bank and pad-side clocks into the fabric clock,
// applying the configured clock polarity (R8).
module iocap_sample_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pad,
  input  logic             ik,
  input  logic             ok,
  input  logic             ce,
  input  logic             ik_inv,
  input  logic             ok_inv,
  output logic [WIDTH-1:0] pad_s,
  output logic             ikp_s,
  output logic             okp_s,
  output logic             ce_s
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_s <= '0;
      ikp_s <= 1'b0;
      okp_s <= 1'b0;
      ce_s  <= 1'b0;
    end else begin
      pad_s <= pad;
      ikp_s <= ik ^ ik_inv;
      okp_s <= ok ^ ok_inv;
      ce_s  <= ce;
    end
  end
endmodule

// File: rtl/iocap_front_latch.sv
// Optional front latch, open while the effective launch clock is low (R6),
// bypassed combinationally when disabled (R7).
module iocap_front_latch #(
  parameter int WIDTH   = 8,
  parameter bit PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             launch,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  generate
    if (PRESENT) begin : g_front
      for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        logic held;
        logic view;

        always_ff @(posedge clk) begin
          if (rst)          held <= 1'b0;
          else if (!launch) held <= d[i];
        end

        assign view = launch ? held : d[i];
        assign q[i] = enable ? view : d[i];
      end
    end else begin : g_none
      logic unused_ok;
      assign unused_ok = &{1'b0, clk, rst, enable, launch};
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/iocap_store.sv
// Per-pad storage element: edge flip-flop (R3) or high-transparent latch (R4),
// with enable (R5) and configured reset value (R1).
module iocap_store
  import iocap_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_val,
  input  cap_mode_e        mode,
  input  logic             cap_clk,
  input  logic             ce,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic cap_prev;
  logic rise;
  logic load;

  assign rise = cap_clk & ~cap_prev;
  assign load = ce & ((mode == CAP_LEVEL) ? cap_clk : rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_prev <= 1'b0;
      q        <= {WIDTH{set_val}};
    end else begin
      cap_prev <= cap_clk;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/iocap_tap.sv
// Tap rank: delays the direct pad path to line up with the stored path
// (R2, R10) and registers the selected source (R9).
module iocap_tap
  import iocap_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tap_src_e         src,
  input  logic [WIDTH-1:0] direct,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] tap
);
  logic [WIDTH-1:0] direct_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      direct_d <= '0;
      tap      <= '0;
    end else begin
      direct_d <= direct;
      tap      <= (src == TAP_REG) ? stored : direct_d;
    end
  end
endmodule

// File: rtl/iocap_input_path.sv
module iocap_input_path
  import iocap_pkg::*;
#(
  parameter int WIDTH         = 8,
  parameter bit FRONT_PRESENT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pad,
  input  logic             ik,
  input  logic             ok,
  input  logic             ce,
  input  logic             cfg_level_mode,
  input  logic             cfg_ik_inv,
  input  logic             cfg_ok_inv,
  input  logic             cfg_front_en,
  input  logic             cfg_set_val,
  input  logic             cfg_tap_a_reg,
  input  logic             cfg_tap_b_reg,
  output logic [WIDTH-1:0] tap_a,
  output logic [WIDTH-1:0] tap_b
);
  logic [WIDTH-1:0] pad_s;
  logic             ikp_s;
  logic             okp_s;
  logic             ce_s;
  logic [WIDTH-1:0] front_q;
  logic [WIDTH-1:0] store_q;
  cap_mode_e        mode;
  tap_src_e         src_a;
  tap_src_e         src_b;

  assign mode  = cap_mode_e'(cfg_level_mode);
  assign src_a = tap_src_e'(cfg_tap_a_reg);
  assign src_b = tap_src_e'(cfg_tap_b_reg);

  iocap_sample_stage #(.WIDTH(WIDTH)) u_sample (
    .clk(clk), .rst(rst), .pad(pad), .ik(ik), .ok(ok), .ce(ce),
    .ik_inv(cfg_ik_inv), .ok_inv(cfg_ok_inv),
    .pad_s(pad_s), .ikp_s(ikp_s), .okp_s(okp_s), .ce_s(ce_s)
  );

  iocap_front_latch #(.WIDTH(WIDTH), .PRESENT(FRONT_PRESENT)) u_front (
    .clk(clk), .rst(rst), .enable(cfg_front_en), .launch(okp_s),
    .d(pad_s), .q(front_q)
  );

  iocap_store #(.WIDTH(WIDTH)) u_store (
    .clk(clk), .rst(rst), .set_val(cfg_set_val), .mode(mode),
    .cap_clk(ikp_s), .ce(ce_s), .d(front_q), .q(store_q)
  );

  iocap_tap #(.WIDTH(WIDTH)) u_tap_a (
    .clk(clk), .rst(rst), .src(src_a), .direct(pad_s), .stored(store_q),
    .tap(tap_a)
  );

  iocap_tap #(.WIDTH(WIDTH)) u_tap_b (
    .clk(clk), .rst(rst), .src(src_b), .direct(pad_s), .stored(store_q),
    .tap(tap_b)
  );
endmodule

// File: rtl/iocap_input_path_chk.sv
module iocap_input_path_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] pad,
  input logic             ik,
  input logic             ce,
  input logic             cfg_level_mode,
  input logic             cfg_ik_inv,
  input logic             cfg_front_en,
  input logic             cfg_tap_a_reg,
  input logic             cfg_tap_b_reg,
  input logic [WIDTH-1:0] tap_a,
  input logic [WIDTH-1:0] tap_b
);
  logic [2:0] live;

  always_ff @(posedge clk) begin
    if (rst)           live <= '0;
    else if (live < 4) live <= live + 3'd1;
  end

  // R1
  reset_clears_taps_chk: assert property (@(posedge clk)
    rst && $past(rst) |=> (tap_a == '0) && (tap_b == '0));

  // R2
  direct_path_delay_chk: assert property (@(posedge clk) disable iff (rst)
    (live >= 3) && !cfg_tap_b_reg |-> tap_b == $past(pad, 3));

  // R5
  enable_low_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (live >= 4) && cfg_tap_a_reg && !$past(ce, 3) |-> $stable(tap_a));

  // R3
  capture_clock_low_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (live >= 4) && cfg_tap_a_reg && !($past(ik, 3) ^ cfg_ik_inv) |-> $stable(tap_a));

  // R4
  level_transparent_chk: assert property (@(posedge clk) disable iff (rst)
    (live >= 3) && cfg_level_mode && !cfg_front_en && cfg_tap_a_reg &&
    $past(ce, 3) && ($past(ik, 3) ^ cfg_ik_inv) |-> tap_a == $past(pad, 3));
endmodule

bind iocap_input_path iocap_input_path_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .pad(pad), .ik(ik), .ce(ce),
  .cfg_level_mode(cfg_level_mode), .cfg_ik_inv(cfg_ik_inv),
  .cfg_front_en(cfg_front_en), .cfg_tap_a_reg(cfg_tap_a_reg),
  .cfg_tap_b_reg(cfg_tap_b_reg), .tap_a(tap_a), .tap_b(tap_b)
);

// File: tb/iocap_input_path_test.sv
`timescale 1ns/1ps
module iocap_input_path_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] pad = '0;
  logic         ik = 1'b0, ok = 1'b0, ce = 1'b0;
  logic         c_lvl = 1'b0, c_iki = 1'b0, c_oki = 1'b0, c_fen = 1'b0;
  logic         c_sv = 1'b0, c_a = 1'b0, c_b = 1'b0;
  logic [W-1:0] tap_a, tap_b;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  iocap_input_path #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .pad(pad), .ik(ik), .ok(ok), .ce(ce),
    .cfg_level_mode(c_lvl), .cfg_ik_inv(c_iki), .cfg_ok_inv(c_oki),
    .cfg_front_en(c_fen), .cfg_set_val(c_sv), .cfg_tap_a_reg(c_a),
    .cfg_tap_b_reg(c_b), .tap_a(tap_a), .tap_b(tap_b)
  );

  // reference model state
  logic         m_prev;
  logic [W-1:0] m_front, m_store;
  logic [W-1:0] ea1, eb1, ea2, eb2;
  int           steps;

  task automatic check(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
    end
  endtask

  // One model step with the inputs seen at a rising edge (R3..R8).
  function automatic void model_step();
    logic         capc, lnch, load;
    logic [W-1:0] fview, d;
    capc  = ik ^ c_iki;
    lnch  = ok ^ c_oki;
    fview = lnch ? m_front : pad;
    d     = c_fen ? fview : pad;
    load  = ce & (c_lvl ? capc : (capc & ~m_prev));
    if (load) m_store = d;
    m_front = fview;
    m_prev  = capc;
  endfunction

  // Drive at falling edge, step at rising edge, compare after it (R10).
  task automatic tick(string tag);
    logic [W-1:0] na, nb;
    @(posedge clk);
    model_step();
    na = c_a ? m_store : pad;
    nb = c_b ? m_store : pad;
    #1;
    if (steps >= 2) begin
      check(c_a ? tag : "R2 direct", tap_a, ea2);
      check(c_b ? tag : "R2 direct", tap_b, eb2);
    end
    ea2 = ea1; eb2 = eb1; ea1 = na; eb1 = nb;
    steps++;
  endtask

  task automatic run_cfg(string tag, bit lvl, bit iki, bit oki, bit fen,
                         bit sv, bit sa, bit sb, int ce_pct, int cycles);
    int ik_cnt = 1, ok_cnt = 1;
    @(negedge clk);
    rst = 1'b1; ce = 1'b0;
    c_lvl = lvl; c_iki = iki; c_oki = oki; c_fen = fen;
    c_sv = sv; c_a = sa; c_b = sb;
    repeat (3) @(negedge clk);
    // R1: taps cleared while reset is held
    check("R1 reset tap_a", tap_a, '0);
    check("R1 reset tap_b", tap_b, '0);
    m_prev = 1'b0; m_front = '0; m_store = {W{sv}}; steps = 0;
    rst = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      pad = W'($urandom);
      ce  = ($urandom % 100) < ce_pct;
      if (--ik_cnt == 0) begin ik = ~ik; ik_cnt = 1 + ($urandom % 5); end
      if (--ok_cnt == 0) begin ok = ~ok; ok_cnt = 1 + ($urandom % 7); end
      tick(tag);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20240917));
    // edge flip-flop, front latch bypassed
    run_cfg("R3 R7", 0, 0, 0, 0, 0, 1, 0, 80, 400);
    // level latch, both taps stored, set value 1
    run_cfg("R4 R1", 1, 0, 0, 0, 1, 1, 1, 80, 400);
    // front latch then edge flip-flop
    run_cfg("R6 R3", 0, 0, 0, 1, 0, 1, 1, 90, 400);
    // front latch then level latch, inverted launch clock
    run_cfg("R6 R8", 1, 0, 1, 1, 1, 1, 0, 90, 400);
    // both clocks inverted
    run_cfg("R8", 0, 1, 1, 1, 0, 0, 1, 85, 400);
    // enable never asserted: stored value stays at set value
    run_cfg("R5 R1", 0, 0, 0, 1, 1, 1, 1, 0, 200);
    run_cfg("R5", 1, 0, 0, 0, 0, 1, 1, 0, 200);
    // independent tap sources
    run_cfg("R9", 1, 1, 0, 1, 0, 0, 1, 70, 400);
    run_cfg("R9", 0, 0, 1, 0, 1, 1, 0, 70, 400);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired got=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule